// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the programmable feedback divider of a frequency synthesiser loop. It runs on the oscillator-rate input clock. A prescaler model divides by either 48 or 49. A swallow counter decides, segment by segment, which of the two ratios the prescaler uses. A main counter counts prescaler segments and closes each division cycle. The total division is M*48 + A. With the legal settings this covers every integer ratio from 2353 to 2544. At a 1 MHz comparison rate that ratio is the oscillator frequency in MHz: M=49 with A=5 gives 2357, and M=50 with A=1 gives 2401.

Software or a serial front end presents new M and A values together with a one-cycle load strobe. The strobe forces every counter to zero and stops counting. On the next input clock with the strobe low, the new values are preloaded and a fresh division cycle starts. Values outside the legal window are clamped to the nearest legal value. The divided output is a single-cycle pulse, given once per full division cycle. The modulus-control output shows which prescaler ratio is in use.

Top module: `pulse_swallow_div`

## Requirements
- R1: After reset, `div_pulse_o` and `modsel_o` stay low and no pulse appears until the first load strobe.
- R2: Once running, consecutive `div_pulse_o` pulses are exactly M*48 + A input clocks apart, for every M in 49..52 and A in 1..48.
- R3: Within each division cycle `modsel_o` (1 = divide by 49, 0 = divide by 48) is high for exactly 49*A input clocks at the start of the cycle and low for the rest. It rises only at the start of a cycle.
- R4: `div_pulse_o` is high for exactly one input clock per division cycle.
- R5: In the clock after any edge where `load_i` is sampled high, `div_pulse_o` and `modsel_o` are low. While `load_i` stays high, no pulse appears.
- R6: The first clock edge with `load_i` low after a strobe preloads the counters. The first pulse is registered M*48 + A edges after that preload edge.
- R7: An A value of 0 is used as 1 and an A value above 48 is used as 48. An M value below 49 is used as 49 and an M value above 52 is used as 52.
- R8: A strobe given in the middle of a division cycle discards the partial count. Timing restarts from the new preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe: clears counters and captures new values |
| a_val_i | input | 6 | Swallow count A (clamped to 1..48) |
| m_val_i | input | 6 | Main count M (clamped to 49..52) |
| div_pulse_o | output | 1 | One-clock pulse per full division cycle |
| modsel_o | output | 1 | Prescaler modulus control, 1 = divide by 49 |

## Verification
The bound checker holds four properties on every cycle. The divided pulse never lasts two clocks. A load strobe always leaves both outputs quiet in the next cycle. The modulus control rises only with a pulse or just after a preload. Every pulse lands inside the legal ratio window. Only the bench scenarios can show the exact ratio for a given M and A, the 49*A split of the modulus control, the clamping of illegal values, and the restart after a strobe given in the middle of a cycle. They do this by counting clocks between pulses against M*48 + A for the chosen settings.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned PSD_N_LOW = 48;
  localparam int unsigned PSD_M_MIN = 49;
  localparam int unsigned PSD_M_MAX = 52;
  localparam int unsigned PSD_A_MIN = 1;
  localparam int unsigned PSD_A_MAX = 48;
  localparam int unsigned PSD_VAL_W = 6;
endpackage

// File: rtl/psd_clamp.sv
module psd_clamp #(
  parameter int unsigned W  = 6,
  parameter int unsigned LO = 1,
  parameter int unsigned HI = 48
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lim_o
);
  always_comb begin
    if (raw_i < W'(LO))      lim_o = W'(LO);
    else if (raw_i > W'(HI)) lim_o = W'(HI);
    else                     lim_o = raw_i;
  end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned LOW = 48,
  parameter int unsigned W   = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic mod_hi_i,
  output logic tick_o
);
  logic [W-1:0] cnt_q, cnt_d, term;

  // terminal count: LOW-1 for /LOW, LOW for /(LOW+1)
  always_comb term = mod_hi_i ? W'(LOW) : W'(LOW - 1);

  always_comb tick_o = en_i && !clr_i && (cnt_q == term);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (en_i) begin
      if (tick_o)    cnt_d = '0;
      else           cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/psd_downcnt.sv
module psd_downcnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                     cnt_d = '0;
    else if (ld_i)                 cnt_d = ld_val_i;
    else if (dec_i && |cnt_q)      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int unsigned N_LOW = PSD_N_LOW,
  parameter int unsigned M_MIN = PSD_M_MIN,
  parameter int unsigned M_MAX = PSD_M_MAX,
  parameter int unsigned A_MIN = PSD_A_MIN,
  parameter int unsigned A_MAX = PSD_A_MAX,
  parameter int unsigned AW    = PSD_VAL_W,
  parameter int unsigned MW    = PSD_VAL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] a_val_i,
  input  logic [MW-1:0] m_val_i,
  output logic          div_pulse_o,
  output logic          modsel_o
);
  localparam int unsigned PW = $clog2(N_LOW + 1);

  logic [AW-1:0] a_lim, a_sh_q, a_sh_d, a_cnt;
  logic [MW-1:0] m_lim, m_sh_q, m_sh_d, m_cnt;
  logic          pend_q, pend_d, run_q, run_d, pulse_q, pulse_d;
  logic          preload, tick, wrap, a_nz, m_last, reload;

  psd_clamp #(.W(AW), .LO(A_MIN), .HI(A_MAX)) u_a_clamp (.raw_i(a_val_i), .lim_o(a_lim));
  psd_clamp #(.W(MW), .LO(M_MIN), .HI(M_MAX)) u_m_clamp (.raw_i(m_val_i), .lim_o(m_lim));

  always_comb begin
    preload = pend_q && !load_i;
    a_nz    = |a_cnt;
    m_last  = (m_cnt == MW'(1));
    wrap    = tick && m_last;
    reload  = preload || wrap;
  end

  psd_prescaler #(.LOW(N_LOW), .W(PW)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load_i),
    .en_i(run_q), .mod_hi_i(a_nz), .tick_o(tick)
  );

  psd_downcnt #(.W(AW)) u_swallow (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load_i), .ld_i(reload),
    .ld_val_i(a_sh_q), .dec_i(tick), .cnt_o(a_cnt)
  );

  psd_downcnt #(.W(MW)) u_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load_i), .ld_i(reload),
    .ld_val_i(m_sh_q), .dec_i(tick), .cnt_o(m_cnt)
  );

  // control next state
  always_comb begin
    a_sh_d  = a_sh_q;
    m_sh_d  = m_sh_q;
    pend_d  = pend_q;
    run_d   = run_q;
    pulse_d = 1'b0;
    if (load_i) begin
      a_sh_d = a_lim;
      m_sh_d = m_lim;
      pend_d = 1'b1;
      run_d  = 1'b0;
    end else if (preload) begin
      pend_d = 1'b0;
      run_d  = 1'b1;
    end else begin
      pulse_d = wrap;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sh_q  <= AW'(A_MIN);
      m_sh_q  <= MW'(M_MIN);
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      a_sh_q  <= a_sh_d;
      m_sh_q  <= m_sh_d;
      pend_q  <= pend_d;
      run_q   <= run_d;
      pulse_q <= pulse_d;
    end
  end

  assign div_pulse_o = pulse_q;
  assign modsel_o    = run_q && a_nz;
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int unsigned N_LOW = 48,
  parameter int unsigned M_MIN = 49,
  parameter int unsigned M_MAX = 52,
  parameter int unsigned A_MIN = 1,
  parameter int unsigned A_MAX = 48
) (
  input logic clk_i,
  input logic rst_ni,
  input logic load_i,
  input logic div_pulse_o,
  input logic modsel_o
);
  localparam int unsigned D_LO = M_MIN * N_LOW + A_MIN;
  localparam int unsigned D_HI = M_MAX * N_LOW + A_MAX;
  localparam int unsigned GW   = $clog2(D_HI + 4) + 1;
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    gap_q <= '0;
    else if (load_i || div_pulse_o) gap_q <= '0;
    else if (gap_q != GMAX)         gap_q <= gap_q + GW'(1);
  end

  // R4
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> !div_pulse_o);

  // R5
  load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!div_pulse_o && !modsel_o));

  // R3
  modsel_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(modsel_o) |-> (div_pulse_o || $past(load_i, 2)));

  // R2
  ratio_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |-> (gap_q >= GW'(D_LO - 1) && gap_q <= GW'(D_HI + 1)));
endmodule

bind pulse_swallow_div psd_checker #(
  .N_LOW(N_LOW), .M_MIN(M_MIN), .M_MAX(M_MAX), .A_MIN(A_MIN), .A_MAX(A_MAX)
) u_psd_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
  .div_pulse_o(div_pulse_o), .modsel_o(modsel_o)
);

// File: tb/tb_pulse_swallow_div.sv
`timescale 1ns/1ps
module tb_pulse_swallow_div;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [5:0] a_val_i = '0;
  logic [5:0] m_val_i = '0;
  logic       div_pulse_o, modsel_o;
  int         total = 0, bad = 0, cyc = 0;
  bit         done = 0;

  pulse_swallow_div dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .a_val_i(a_val_i),
    .m_val_i(m_val_i), .div_pulse_o(div_pulse_o), .modsel_o(modsel_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // strobe load for one cycle; check quiet outputs (R5)
  task automatic strobe(input int a, input int m);
    @(negedge clk_i);
    load_i = 1'b1; a_val_i = 6'(a); m_val_i = 6'(m);
    @(negedge clk_i);
    chk(!div_pulse_o && !modsel_o, "R5 quiet after strobe",
        int'({div_pulse_o, modsel_o}), 0);
    load_i = 1'b0;
  endtask

  // negedges until a pulse is seen, capped
  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!div_pulse_o && n < 3000);
  endtask

  // one steady period starting at a pulse negedge: length and modsel count
  task automatic steady(input int exp_d, input int exp_mod, input string tag);
    int n = 1;
    int mods = modsel_o ? 1 : 0;
    @(negedge clk_i);
    chk(!div_pulse_o, "R4 pulse width one clock", int'(div_pulse_o), 0);
    while (!div_pulse_o && n < 3000) begin
      if (modsel_o) mods++;
      n++;
      @(negedge clk_i);
    end
    chk(n == exp_d, {tag, " R2 period"}, n, exp_d);
    chk(mods == exp_mod, {tag, " R3 modsel cycles"}, mods, exp_mod);
  endtask

  task automatic run_pair(input int a, input int m, input int ea, input int em, input string tag);
    int n;
    int d = em * 48 + ea;
    strobe(a, m);
    wait_pulse(n);
    chk(n == d + 1, {tag, " R6 first pulse after preload"}, n, d + 1);
    steady(d, 49 * ea, tag);
  endtask

  task automatic t_reset();
    int hits = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      if (div_pulse_o || modsel_o) hits++;
    end
    chk(hits == 0, "R1 idle after reset", hits, 0);
  endtask

  task automatic t_sweep();
    int alist[4] = '{1, 2, 47, 48};
    for (int m = 49; m <= 52; m++)
      for (int k = 0; k < 4; k++)
        run_pair(alist[k], m, alist[k], m, "R2 sweep");
  endtask

  task automatic t_clamp();
    run_pair(0, 10, 1, 49, "R7 low clamp");
    run_pair(63, 63, 48, 52, "R7 high clamp");
    run_pair(49, 48, 48, 49, "R7 edge clamp");
  endtask

  task automatic t_hold();
    int hits = 0;
    int n;
    @(negedge clk_i);
    load_i = 1'b1; a_val_i = 6'd5; m_val_i = 6'd49;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (div_pulse_o || modsel_o) hits++;
    end
    chk(hits == 0, "R5 held strobe keeps outputs low", hits, 0);
    load_i = 1'b0;
    wait_pulse(n);
    chk(n == 2357 + 1, "R6 first pulse after held strobe", n, 2358);
  endtask

  task automatic t_midload();
    int n;
    strobe(48, 52);
    repeat (1000) @(negedge clk_i);
    chk(!div_pulse_o, "R8 no pulse yet mid cycle", int'(div_pulse_o), 0);
    strobe(1, 50);
    wait_pulse(n);
    chk(n == 2401 + 1, "R8 restart after mid-cycle strobe", n, 2402);
    steady(2401, 49, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!div_pulse_o && !modsel_o, "R1 outputs in reset",
        int'({div_pulse_o, modsel_o}), 0);
    rst_ni = 1'b1;
    t_reset();
    t_sweep();
    t_clamp();
    t_hold();
    t_midload();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule